// File: doc/BRIEF.md
# Per-Line Configurable Edge Event Detector

This block watches a 256-line input bus and reports, one cycle later, which lines saw an edge. Each line has its own 2-bit edge mode: rising only, falling only, either edge (toggle), or a reserved value that never fires. Each line also has a suppress bit that silences its events. The modes live in a bank of 32-bit control words, with sixteen lines in each word. The suppress bits live in a second bank of 32-bit words, with thirty-two lines in each word. Both banks are reached through a plain word-wide read/write register port. The block outputs a registered per-line event vector and a single any-event flag.

A small two-state sequencer guards the first sample after reset. The state `ST_PRIME` is entered on reset. It holds for exactly one clock, and on that edge the previous-value register is loaded and no events are produced. The sequencer then takes the transition `ST_PRIME -> ST_RUN`. It stays in `ST_RUN` through the transition `ST_RUN -> ST_RUN` until the next reset.

An instance may build fewer words than the maximum in either bank. Addresses of words that are not built behave as empty: writes to them are dropped and reads return zero.

Top module: `multi_edge_detector`

## Requirements
- R1: While reset is asserted and directly after it, `event_out` and `any_event` are zero and every register word reads zero.
- R2: Mode 2'b00 (rising): a line fires when the value sampled at the previous edge was 0 and the value at the current edge is 1.
- R3: Mode 2'b01 (falling): a line fires when the previous sample was 1 and the current sample is 0.
- R4: Mode 2'b10 (toggle): a line fires on any change between consecutive samples.
- R5: Mode 2'b11 is reserved and never produces an event.
- R6: Line i takes its mode from control word i/16 (word address i/16), bits 2*(i%16)+1 down to 2*(i%16). Its suppress bit is bit i%32 of mask word i/32, at word address 16 + i/32.
- R7: When a line's suppress bit is 1, no event is reported on that line. When the bit is 0, its events pass.
- R8: A write to an unbuilt control or mask word, or to an address from 24 to 31, changes nothing, and a read of such an address returns zero.
- R9: A write replaces exactly the addressed 32-bit word. A read, a change to one field and a write-back leave every other field of that word intact.
- R10: An event is visible for exactly the one cycle after the clock edge that samples the change. A line held steady produces no event.
- R11: The first clock edge after reset only loads the previous-value register and produces no events, even if inputs differ from zero.
- R12: `any_event` is 1 exactly in cycles where at least one bit of `event_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: 0-15 control, 16-23 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lines_in | input | 256 | Monitored input lines |
| event_out | output | 256 | Registered per-line events |
| any_event | output | 1 | OR of all reported events |

## Verification
The detector is first driven with whole-bus transitions, all lines rising and then all lines falling. These show which modes fire in which direction. Alternating patterns across groups of lines set to falling, toggle and reserved modes then show that each encoding is decoded apart from the others, and that the decode happens in the right bit pair. Pseudo-random bus values with a mix of suppress bits exercise the any-event reduction and the one-cycle event window. Held inputs and a single isolated line change show that events last one cycle and need a real change. The first sample after reset is taken with all lines high, so that a premature compare would show up as 256 false rising events.

// File: rtl/mled_pkg.sv
package mled_pkg;
    localparam int WORD_W         = 32;
    localparam int MODE_W         = 2;
    localparam int LINES_PER_CTRL = WORD_W / MODE_W;
    localparam int LINES_PER_MASK = WORD_W;

    typedef enum logic [1:0] {
        EM_RISE = 2'b00,
        EM_FALL = 2'b01,
        EM_BOTH = 2'b10,
        EM_RSVD = 2'b11
    } edge_mode_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } prime_state_e;
endpackage

// File: rtl/mled_cfg_bank.sv
module mled_cfg_bank #(
    parameter int NUM_WORDS  = 16,
    parameter int IMPL_WORDS = 16,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output logic [NUM_WORDS*WORD_W-1:0]   words_flat
);
    logic [WORD_W-1:0] word_arr [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (w < IMPL_WORDS) begin : g_built
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_arr[w] <= '0;
                else if (wr_en && (int'(idx) == w))
                    word_arr[w] <= wdata;
            end
        end else begin : g_empty
            assign word_arr[w] = '0;
        end
        assign words_flat[w*WORD_W +: WORD_W] = word_arr[w];
    end

    assign rdata = word_arr[idx];

    // R8: an unbuilt word always reads empty
    p_unbuilt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx) >= IMPL_WORDS) |-> (rdata == '0));

    // R9: a write to a built word is read back whole on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(idx) < IMPL_WORDS)) |=>
        ((idx != $past(idx)) || (rdata == $past(wdata))));
endmodule

// File: rtl/mled_line_cell.sv
module mled_line_cell
    import mled_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       prev_v,
    input  logic       cur_v,
    output logic       hit
);
    logic rise, fall;

    assign rise = !prev_v &&  cur_v;
    assign fall =  prev_v && !cur_v;

    always_comb begin
        unique case (edge_mode_e'(mode))
            EM_RISE: hit = rise;
            EM_FALL: hit = fall;
            EM_BOTH: hit = rise || fall;
            EM_RSVD: hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/mled_prime_fsm.sv
module mled_prime_fsm
    import mled_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic primed
);
    prime_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_PRIME;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        primed  = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                state_d = ST_RUN;
                primed  = 1'b0;
            end
            ST_RUN: begin
                state_d = ST_RUN;
                primed  = 1'b1;
            end
            default: begin
                state_d = ST_PRIME;
                primed  = 1'b0;
            end
        endcase
    end

    // R11: once running, the sequencer never returns to priming
    p_run_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
endmodule

// File: rtl/multi_edge_detector.sv
module multi_edge_detector
    import mled_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int CTRL_BUILT = 16,
    parameter int MASK_BUILT = 8,
    localparam int CTRL_WORDS = NUM_LINES / LINES_PER_CTRL,
    localparam int MASK_WORDS = NUM_LINES / LINES_PER_MASK,
    localparam int CIDX_W     = $clog2(CTRL_WORDS),
    localparam int MIDX_W     = $clog2(MASK_WORDS),
    localparam int ADDR_W     = CIDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] event_out,
    output logic                 any_event
);
    logic                          ctrl_sel, mask_sel;
    logic [WORD_W-1:0]             ctrl_rd, mask_rd;
    logic [CTRL_WORDS*WORD_W-1:0]  ctrl_flat;
    logic [MASK_WORDS*WORD_W-1:0]  mask_flat;
    logic [NUM_LINES-1:0]          prev_q, raw_hit, rsvd_vec, pass_hit;
    logic                          primed;

    assign ctrl_sel = (int'(reg_addr) < CTRL_WORDS);
    assign mask_sel = !ctrl_sel && (int'(reg_addr) < CTRL_WORDS + MASK_WORDS);

    mled_cfg_bank #(.NUM_WORDS(CTRL_WORDS), .IMPL_WORDS(CTRL_BUILT), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we && ctrl_sel),
        .idx(reg_addr[CIDX_W-1:0]), .wdata(reg_wdata),
        .rdata(ctrl_rd), .words_flat(ctrl_flat)
    );

    mled_cfg_bank #(.NUM_WORDS(MASK_WORDS), .IMPL_WORDS(MASK_BUILT), .WORD_W(WORD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we && mask_sel),
        .idx(reg_addr[MIDX_W-1:0]), .wdata(reg_wdata),
        .rdata(mask_rd), .words_flat(mask_flat)
    );

    always_comb begin
        if (ctrl_sel)      reg_rdata = ctrl_rd;
        else if (mask_sel) reg_rdata = mask_rd;
        else               reg_rdata = '0;
    end

    mled_prime_fsm u_prime (.clk(clk), .rst_n(rst_n), .primed(primed));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        mled_line_cell u_cell (
            .mode  (ctrl_flat[MODE_W*i +: MODE_W]),
            .prev_v(prev_q[i]),
            .cur_v (lines_in[i]),
            .hit   (raw_hit[i])
        );
        assign rsvd_vec[i] = (ctrl_flat[MODE_W*i +: MODE_W] == EM_RSVD);
    end

    assign pass_hit = raw_hit & ~mask_flat[NUM_LINES-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            event_out <= '0;
            any_event <= 1'b0;
        end else begin
            prev_q <= lines_in;
            if (primed) begin
                event_out <= pass_hit;
                any_event <= |pass_hit;
            end else begin
                event_out <= '0;
                any_event <= 1'b0;
            end
        end
    end

    // R12: the summary flag agrees with the event vector
    p_any_or_r12: assert property (@(posedge clk) disable iff (!rst_n)
        any_event == (|event_out));

    // R7: suppressed lines stay silent
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((event_out & $past(mask_flat[NUM_LINES-1:0])) == '0));

    // R5: reserved-mode lines stay silent
    p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((event_out & $past(rsvd_vec)) == '0));

    // R10: an event needs a real change between consecutive samples
    p_needs_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((event_out & ~($past(lines_in) ^ $past(prev_q))) == '0));

    // R11: the priming edge yields nothing
    p_prime_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> (event_out == '0));
endmodule

// File: tb/multi_edge_detector_tb_top.sv
module multi_edge_detector_tb_top;
    localparam int NL = 256;
    localparam int CB = 12;
    localparam int MB = 6;

    typedef struct {
        logic [NL-1:0] ev;
        logic          any;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] lines_in = '1;
    logic [NL-1:0] event_out;
    logic          any_event;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exp_t          sb_q[$];
    logic [31:0]   ctrl_m [16];
    logic [31:0]   mask_m [8];
    logic [NL-1:0] prev_m = '0;
    bit            primed_m = 1'b0;
    logic [31:0]   lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    multi_edge_detector #(.NUM_LINES(NL), .CTRL_BUILT(CB), .MASK_BUILT(MB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lines_in(lines_in),
        .event_out(event_out), .any_event(any_event)
    );

    function automatic logic [NL-1:0] model_ev(input logic [NL-1:0] p, input logic [NL-1:0] c);
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) begin
            logic [1:0] m;
            logic up, dn, h;
            m  = ctrl_m[i/16][2*(i%16) +: 2];
            up = !p[i] && c[i];
            dn = p[i] && !c[i];
            case (m)
                2'b00:   h = up;
                2'b01:   h = dn;
                2'b10:   h = up || dn;
                default: h = 1'b0;
            endcase
            r[i] = h && !mask_m[i/32][i%32];
        end
        return r;
    endfunction

    task automatic step(input logic [NL-1:0] nl, input bit dowr, input logic [4:0] a,
                        input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n     = 1'b1;
        lines_in  = nl;
        reg_we    = dowr;
        reg_addr  = a;
        reg_wdata = d;
        e.ev  = primed_m ? model_ev(prev_m, nl) : '0;
        e.any = |e.ev;
        e.tag = tag;
        sb_q.push_back(e);
        if (dowr) begin
            if (a < CB) ctrl_m[a] = d;
            else if (a >= 16 && a < 16 + MB) mask_m[a-16] = d;
        end
        prev_m   = nl;
        primed_m = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step(lines_in, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp_v, input string tag);
        step(lines_in, 1'b0, a, '0, tag);
        #1;
        checks++;
        if (reg_rdata !== exp_v) begin
            failures++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, reg_rdata, exp_v);
        end
    endtask

    function automatic logic [NL-1:0] rand_bus();
        logic [NL-1:0] v;
        for (int k = 0; k < NL/32; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            v[k*32 +: 32] = lfsr;
        end
        return v;
    endfunction

    // monitor: compare each produced cycle against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (event_out !== e.ev) begin
                    failures++;
                    $display("FAIL %s event_out actual=%h expected=%h", e.tag, event_out, e.ev);
                end
                checks++;
                if (any_event !== e.any) begin
                    failures++;
                    $display("FAIL R12 any_event (%s) actual=%b expected=%b", e.tag, any_event, e.any);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NL-1:0] v;
        logic [31:0]   w;
        for (int k = 0; k < 16; k++) ctrl_m[k] = '0;
        for (int k = 0; k < 8; k++)  mask_m[k] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (event_out !== '0 || any_event !== 1'b0) begin
            failures++;
            $display("FAIL R1 outputs in reset actual=%b/%b expected=0/0", |event_out, any_event);
        end
        checks++;
        if (reg_rdata !== '0) begin
            failures++;
            $display("FAIL R1 rdata in reset actual=%h expected=0", reg_rdata);
        end

        // R11: first edge with all lines high must not fire
        step('1, 1'b0, 5'd0, '0, "R11");
        rd(5'd0, 32'h0, "R1");
        rd(5'd16, 32'h0, "R1");

        // R2: default rising mode
        step('0, 1'b0, 5'd0, '0, "R2");
        step('1, 1'b0, 5'd0, '0, "R2");
        step('1, 1'b0, 5'd0, '0, "R10");

        // R3/R4/R5/R6 configuration
        wr(5'd0, 32'h5555_5555, "R3");
        wr(5'd1, 32'hAAAA_AAAA, "R4");
        wr(5'd2, 32'hFFFF_FFFF, "R5");
        wr(5'd3, 32'h0000_0010, "R6");
        rd(5'd1, 32'hAAAA_AAAA, "R9");
        step('0, 1'b0, 5'd0, '0, "R3");
        step('1, 1'b0, 5'd0, '0, "R4");
        step({NL/2{2'b01}}, 1'b0, 5'd0, '0, "R5");
        step({NL/2{2'b10}}, 1'b0, 5'd0, '0, "R6");
        // isolated change on line 50 (falling mode via word 3 bits 5:4)
        v = '1; step(v, 1'b0, 5'd0, '0, "R6");
        v[50] = 1'b0; step(v, 1'b0, 5'd0, '0, "R6");
        step(v, 1'b0, 5'd0, '0, "R10");

        // R7: suppression
        wr(5'd16, 32'h0000_FFFF, "R7");
        wr(5'd17, 32'h0000_0001, "R7");
        rd(5'd17, 32'h0000_0001, "R7");
        step('0, 1'b0, 5'd0, '0, "R7");
        step('1, 1'b0, 5'd0, '0, "R7");
        step('0, 1'b0, 5'd0, '0, "R7");

        // R9: read-modify-write of line 20's field (word 1 bits 9:8)
        rd(5'd1, 32'hAAAA_AAAA, "R9");
        w = 32'hAAAA_AAAA;
        w[9:8] = 2'b00;
        wr(5'd1, w, "R9");
        rd(5'd1, 32'hAAAA_A8AA, "R9");
        rd(5'd0, 32'h5555_5555, "R9");
        step('1, 1'b0, 5'd0, '0, "R9");

        // R8: unbuilt and unmapped addresses
        wr(5'd12, 32'h5555_5555, "R8");
        wr(5'd15, 32'hFFFF_FFFF, "R8");
        wr(5'd22, 32'hFFFF_FFFF, "R8");
        wr(5'd27, 32'hFFFF_FFFF, "R8");
        rd(5'd12, 32'h0, "R8");
        rd(5'd15, 32'h0, "R8");
        rd(5'd22, 32'h0, "R8");
        rd(5'd27, 32'h0, "R8");
        rd(5'd11, 32'h0, "R8");
        // lines 192..255: rising mode and unmasked despite the writes
        v = '1; v[255:192] = '0;
        step(v, 1'b0, 5'd0, '0, "R8");
        step('1, 1'b0, 5'd0, '0, "R8");

        // R10/R12: pseudo-random traffic with mixed mask
        wr(5'd18, 32'h0F0F_00FF, "R12");
        wr(5'd4, 32'h1B1B_E4E4, "R12");
        for (int n = 0; n < 40; n++) step(rand_bus(), 1'b0, 5'd0, '0, "R12");
        step('0, 1'b0, 5'd0, '0, "R10");
        step('0, 1'b0, 5'd0, '0, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule